// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire bus that a target device holds with its data line low, for example after the controller was interrupted mid-byte. On request it takes over the clock line and issues a burst of clock pulses. During the burst it leaves the data line released, so the target can finish shifting out its byte and let go. The burst stops early as soon as the data line is seen high. When the burst ends, clock control returns to the normal master engine.

Software programs the pulse count and the glitch-filter option in an 8-bit configuration register, raises the request, and polls the self-clearing request bit and the sticky done flag. Between attempts it reads the live line levels through the monitor port. The bus lines are open-drain: an `*_oe` output of 1 pulls the line low.

The sequencer has six states:
- S_IDLE: the master's line drives pass through.
- S_CHECK: decides whether another pulse is needed.
- S_LOW: drives the clock low for one half period.
- S_RELEASE: lets the clock go and waits until the clock line reads high, which allows for clock stretching.
- S_HIGH: holds the clock released for one half period.
- S_FINISH: sets done and clears the request.

The transitions are:
- S_IDLE to S_CHECK on an accepted request.
- S_CHECK to S_FINISH when no pulses remain or SDA reads high.
- S_CHECK to S_LOW otherwise.
- S_LOW to S_RELEASE when the half-period timer expires.
- S_RELEASE to S_HIGH when SCL reads high.
- S_HIGH to S_CHECK when the timer expires, counting one pulse.
- S_FINISH to S_IDLE unconditionally.

Top module: `rcv_bus_recovery`

## Requirements
- R1: `mon_rdata` bit 0 shows the SDA level and bit 1 shows the SCL level, where 1 means high. Both levels pass through a two-stage synchronizer.
- R2: `bus_stuck` is 1 unless both monitored lines are high.
- R3: A write of `cfg_wdata` stores bits 3:0 (pulse count) and bit 7 (glitch-filter bypass). `cfg_rdata` returns those bits, with bits 6:4 reading 0. The register resets to 0.
- R4: An accepted `req_set` raises `req_bit`, which clears itself when the burst ends. At that same point the sticky `done` flag is set. `done` is cleared only by the next accepted request.
- R5: Each pulse drives SCL low for exactly HALF_CYC cycles. The clock then stays released for at least HALF_CYC cycles after SCL is observed high, so a stretched clock lengthens the gap between pulses.
- R6: While SDA stays low, the burst issues min(count, MAX_PULSES) pulses, with MAX_PULSES = 9.
- R7: Before each pulse the burst ends if SDA reads high. If SDA is already high at the request, no pulse is issued.
- R8: A count of 0 completes with `done` set and no pulse.
- R9: A `req_set` that arrives while a burst is running is ignored. The pulse count is unchanged.
- R10: SDA is released for the whole burst, and the master's `mst_*_oe` inputs are ignored during the burst. In S_IDLE the master's inputs drive `sda_oe` and `scl_oe` directly.
- R11: When bit 7 of the configuration is 0, an SDA change lasting fewer than FILT_LEN (4) cycles never reaches the monitor or the sequencer. When bit 7 is 1, the synchronized SDA is used directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Data line level from the pad |
| scl_in | input | 1 | Clock line level from the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| scl_oe | output | 1 | 1 pulls the clock line low |
| mst_sda_oe | input | 1 | Master engine data pull-down request |
| mst_scl_oe | input | 1 | Master engine clock pull-down request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data: [3:0] count, [7] filter bypass |
| cfg_rdata | output | 8 | Configuration readback |
| req_set | input | 1 | Recovery request pulse |
| req_bit | output | 1 | Request bit, 1 while the burst runs |
| done | output | 1 | Sticky burst-complete flag |
| mon_rdata | output | 2 | Line monitor: [0] SDA, [1] SCL |
| bus_stuck | output | 1 | 1 unless both lines read high |

## Verification
The bench models a target that holds SDA until it has seen a chosen number of clock releases, and that can stretch SCL.

It checks the corner cases of the pulse count:
- A count above nine must be clamped to nine. A design without the clamp would emit fifteen pulses.
- A count of zero must finish with no pulse. A design that counts down before testing would wrap around and pulse many times.
- An early SDA release must stop the burst at the pulse that freed the bus. A design that only counts would keep pulsing.

It checks timing and control:
- A stretched clock must widen the gap between pulses. A design that does not wait for SCL to read high would shorten the high phase.
- A second request during a burst must not restart the count.
- The master's pull-down requests must not leak onto the lines mid-burst.

It checks the glitch filter with a two-cycle SDA dip. The dip must be hidden when the filter is active and visible when it is bypassed.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_CHECK   = 3'd1,
        S_LOW     = 3'd2,
        S_RELEASE = 3'd3,
        S_HIGH    = 3'd4,
        S_FINISH  = 3'd5
    } rcv_state_e;

    localparam int CFG_W      = 8;
    localparam int CFG_CNT_W  = 4;
    localparam int CFG_BYP_BIT = 7;

endpackage

// File: rtl/rcv_line_sync.sv
module rcv_line_sync #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic bypass,
    output logic line_o
);
    localparam int FW = $clog2(FILT_LEN + 1);

    logic [STAGES-1:0] chain_q;
    logic              filt_q;
    logic [FW-1:0]     run_q;
    logic              line_s;

    // Synchronizer chain, lines idle high
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign line_s = chain_q[STAGES-1];

    // Glitch filter: output follows only after FILT_LEN consecutive mismatches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            run_q  <= '0;
        end else if (line_s == filt_q) begin
            run_q <= '0;
        end else if (run_q == FW'(FILT_LEN - 1)) begin
            filt_q <= line_s;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign line_o = bypass ? line_s : filt_q;

    // R11: the filtered level only flips after a full run of mismatches
    assert_filter_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> $past(run_q) == FW'(FILT_LEN - 1));

endmodule

// File: rtl/rcv_half_timer.sv
module rcv_half_timer #(
    parameter int HALF_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(HALF_CYC + 1);

    logic [TW-1:0] cnt_q;

    assign expired = run && (cnt_q == TW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (expired) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    assert_timer_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(HALF_CYC - 1));

endmodule

// File: rtl/rcv_seq.sv
module rcv_seq
    import rcv_pkg::*;
#(
    parameter int HALF_CYC   = 1000,
    parameter int MAX_PULSES = 9,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_cfg,
    input  logic             sda_hi,
    input  logic             scl_hi,
    output logic             busy,
    output logic             scl_drive,
    output logic             done
);
    localparam int RW = $clog2(MAX_PULSES + 1);

    rcv_state_e     state_q, state_d;
    logic [RW-1:0]  remaining_q;
    logic [RW-1:0]  pulse_q;
    logic [RW-1:0]  req_cnt;
    logic           done_q;
    logic           tmr_run;
    logic           tmr_exp;

    rcv_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    assign req_cnt = (int'(cnt_cfg) > MAX_PULSES) ? RW'(MAX_PULSES) : RW'(cnt_cfg);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_CHECK;
            S_CHECK:   state_d = (remaining_q == '0 || sda_hi) ? S_FINISH : S_LOW;
            S_LOW:     if (tmr_exp) state_d = S_RELEASE;
            S_RELEASE: if (scl_hi) state_d = S_HIGH;
            S_HIGH:    if (tmr_exp) state_d = S_CHECK;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register and burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            remaining_q <= '0;
            pulse_q     <= '0;
            done_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                remaining_q <= req_cnt;
                pulse_q     <= '0;
                done_q      <= 1'b0;
            end else if (state_q == S_HIGH && tmr_exp) begin
                remaining_q <= remaining_q - 1'b1;
                pulse_q     <= pulse_q + 1'b1;
            end else if (state_q == S_FINISH) begin
                done_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        scl_drive = (state_q == S_LOW);
        tmr_run   = (state_q == S_LOW) || (state_q == S_HIGH);
        done      = done_q;
    end

    assert_low_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOW && !tmr_exp) |=> state_q == S_LOW);

    assert_release_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE && !scl_hi) |=> state_q == S_RELEASE);

    assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q <= RW'(MAX_PULSES));

    assert_abandon_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && sda_hi) |=> state_q == S_FINISH);

    assert_zero_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && remaining_q == '0) |=> state_q == S_FINISH);

    assert_ignore_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_LOW, S_RELEASE} && start) |=> $stable(remaining_q));

    assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);

endmodule

// File: rtl/rcv_bus_recovery.sv
module rcv_bus_recovery
    import rcv_pkg::*;
#(
    parameter int HALF_CYC    = 1000,
    parameter int MAX_PULSES  = 9,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_oe,
    output logic             scl_oe,
    input  logic             mst_sda_oe,
    input  logic             mst_scl_oe,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             req_set,
    output logic             req_bit,
    output logic             done,
    output logic [1:0]       mon_rdata,
    output logic             bus_stuck
);
    logic [CFG_CNT_W-1:0] cnt_q;
    logic                 byp_q;
    logic [1:0]           line_pad;
    logic [1:0]           line_bypass;
    logic [1:0]           line_lvl;
    logic                 busy;
    logic                 scl_drive;

    // Configuration register: count and filter bypass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            byp_q <= 1'b0;
        end else if (cfg_we) begin
            cnt_q <= cfg_wdata[CFG_CNT_W-1:0];
            byp_q <= cfg_wdata[CFG_BYP_BIT];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[CFG_CNT_W-1:0] = cnt_q;
        cfg_rdata[CFG_BYP_BIT]   = byp_q;
    end

    // Line monitoring: index 0 is SDA (filterable), index 1 is SCL
    assign line_pad    = {scl_in, sda_in};
    assign line_bypass = {1'b1, byp_q};

    generate
        for (genvar l = 0; l < 2; l++) begin : g_line
            rcv_line_sync #(
                .STAGES   (SYNC_STAGES),
                .FILT_LEN (FILT_LEN)
            ) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_in (line_pad[l]),
                .bypass  (line_bypass[l]),
                .line_o  (line_lvl[l])
            );
        end
    endgenerate

    assign mon_rdata = line_lvl;
    assign bus_stuck = !(line_lvl[0] && line_lvl[1]);

    rcv_seq #(
        .HALF_CYC   (HALF_CYC),
        .MAX_PULSES (MAX_PULSES),
        .CNT_W      (CFG_CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_set),
        .cnt_cfg   (cnt_q),
        .sda_hi    (line_lvl[0]),
        .scl_hi    (line_lvl[1]),
        .busy      (busy),
        .scl_drive (scl_drive),
        .done      (done)
    );

    // Line ownership: sequencer during burst, master otherwise
    assign req_bit = busy;
    assign sda_oe  = busy ? 1'b0 : mst_sda_oe;
    assign scl_oe  = busy ? scl_drive : mst_scl_oe;

    assert_sda_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_bit |-> !sda_oe);

    assert_idle_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_bit && mst_scl_oe) |-> scl_oe);

    assert_cfg_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[CFG_CNT_W-1:0] == $past(cfg_wdata[CFG_CNT_W-1:0]));

endmodule

// File: tb/rcv_bus_recovery_tb.sv
`timescale 1ns/1ps
module rcv_bus_recovery_tb;
    localparam int HALF = 16;
    localparam int FL   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sda_oe, scl_oe;
    logic       mst_sda_oe = 1'b0, mst_scl_oe = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       req_set = 1'b0;
    logic       req_bit, done, bus_stuck;
    logic [1:0] mon_rdata;

    logic tgt_hold = 1'b0;
    logic glitch_low = 1'b0;
    int   rel_after = 0;
    int   stretch_amt = 0;
    int   stretch_cnt = 0;
    int   tgt_cnt = 0;
    logic sda_in, scl_in;

    int   total = 0, bad = 0;
    logic prev_oe = 1'b0;
    logic in_pulse = 1'b0;
    int   pulses = 0, low_run = 0, high_run = 0;
    int   min_low = 1000000, max_low = 0, min_gap = 1000000;
    logic sda_leak = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_in = !scl_oe && (stretch_cnt == 0);
    assign sda_in = !sda_oe && !tgt_hold && !glitch_low;

    rcv_bus_recovery #(.HALF_CYC(HALF), .FILT_LEN(FL)) u_dut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .mst_sda_oe(mst_sda_oe),
        .mst_scl_oe(mst_scl_oe), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_set(req_set), .req_bit(req_bit),
        .done(done), .mon_rdata(mon_rdata), .bus_stuck(bus_stuck)
    );

    // Bus observer and target model, sampled mid high phase
    always @(posedge clk) begin
        #1;
        if (stretch_cnt > 0) stretch_cnt = stretch_cnt - 1;
        if (scl_oe) begin
            if (!prev_oe && req_bit) begin
                if (pulses > 0 && high_run < min_gap) min_gap = high_run;
                pulses = pulses + 1;
                in_pulse = 1'b1;
            end
            low_run = low_run + 1;
            high_run = 0;
        end else begin
            if (prev_oe && in_pulse) begin
                if (low_run < min_low) min_low = low_run;
                if (low_run > max_low) max_low = low_run;
                stretch_cnt = stretch_amt;
                tgt_cnt = tgt_cnt + 1;
                if (rel_after != 0 && tgt_cnt == rel_after) tgt_hold = 1'b0;
                in_pulse = 1'b0;
            end
            low_run = 0;
            high_run = high_run + 1;
        end
        if (req_bit && sda_oe) sda_leak = 1'b1;
        prev_oe = scl_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); req_set = 1'b1;
        @(negedge clk); req_set = 1'b0;
    endtask

    task automatic clear_stats();
        @(negedge clk);
        pulses = 0; min_low = 1000000; max_low = 0; min_gap = 1000000;
        sda_leak = 1'b0; tgt_cnt = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (req_bit && n < 20000) begin @(negedge clk); n++; end
        chk(!req_bit, {tag, " burst ends"}, n, 20000);
        wait_cyc(3);
    endtask

    task automatic run_burst(input string tag, input int cnt, input int hold,
                             input int rel, input int str, input int exp_p);
        cfg_write(8'(cnt));
        tgt_hold = hold[0]; rel_after = rel; stretch_amt = str;
        wait_cyc(12);
        clear_stats();
        pulse_req();
        wait_idle(tag);
        chk(pulses == exp_p, {tag, " pulse count"}, pulses, exp_p);
        chk(done == 1'b1, {tag, " R4 done set"}, done, 1);
        chk(!sda_leak, {tag, " R10 sda released"}, sda_leak, 0);
        if (exp_p > 0) begin
            chk(min_low == HALF && max_low == HALF, {tag, " R5 low width"}, max_low, HALF);
        end
        tgt_hold = 1'b0; rel_after = 0; stretch_amt = 0;
        wait_cyc(12);
    endtask

    task automatic t_reset();
        chk(cfg_rdata == 8'h00, "R3 reset cfg", cfg_rdata, 0);
        chk(!req_bit && !done, "R4 reset idle", {req_bit, done}, 0);
        chk(mon_rdata == 2'b11, "R1 reset monitor", mon_rdata, 3);
        chk(!bus_stuck, "R2 reset not stuck", bus_stuck, 0);
        chk(!scl_oe && !sda_oe, "R10 reset lines free", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_cfg();
        cfg_write(8'hFF);
        chk(cfg_rdata == 8'h8F, "R3 readback", cfg_rdata, 8'h8F);
        cfg_write(8'h05);
        chk(cfg_rdata == 8'h05, "R3 readback2", cfg_rdata, 5);
    endtask

    task automatic t_monitor();
        tgt_hold = 1'b1; wait_cyc(12);
        chk(mon_rdata == 2'b10, "R1 sda low", mon_rdata, 2);
        chk(bus_stuck, "R2 stuck sda", bus_stuck, 1);
        tgt_hold = 1'b0; mst_scl_oe = 1'b1; wait_cyc(12);
        chk(scl_oe == 1'b1, "R10 idle passthrough", scl_oe, 1);
        chk(mon_rdata == 2'b01, "R1 scl low", mon_rdata, 1);
        chk(bus_stuck, "R2 stuck scl", bus_stuck, 1);
        mst_scl_oe = 1'b0; wait_cyc(12);
        chk(!bus_stuck, "R2 free", bus_stuck, 0);
    endtask

    task automatic t_ignore_req_R9();
        cfg_write(8'h04);
        tgt_hold = 1'b1; wait_cyc(12);
        clear_stats();
        pulse_req();
        wait_cyc(30);
        pulse_req();
        wait_cyc(40);
        pulse_req();
        wait_idle("R9");
        chk(pulses == 4, "R9 second request ignored", pulses, 4);
        tgt_hold = 1'b0; wait_cyc(12);
    endtask

    task automatic t_done_clear_R4();
        cfg_write(8'h02);
        tgt_hold = 1'b1; wait_cyc(12);
        chk(done, "R4 done sticky before", done, 1);
        pulse_req();
        chk(!done && req_bit, "R4 done cleared on request", {done, req_bit}, 1);
        wait_idle("R4");
        chk(done && !req_bit, "R4 request self clears", {done, req_bit}, 2);
        tgt_hold = 1'b0; wait_cyc(12);
    endtask

    task automatic t_master_ignored_R10();
        cfg_write(8'h03);
        tgt_hold = 1'b1; wait_cyc(12);
        clear_stats();
        pulse_req();
        mst_scl_oe = 1'b1; mst_sda_oe = 1'b1;
        wait_idle("R10");
        chk(pulses == 3, "R10 master ignored pulses", pulses, 3);
        chk(!sda_leak, "R10 master sda ignored", sda_leak, 0);
        chk(scl_oe && sda_oe, "R10 control returned", {scl_oe, sda_oe}, 3);
        mst_scl_oe = 1'b0; mst_sda_oe = 1'b0; tgt_hold = 1'b0; wait_cyc(12);
    endtask

    task automatic t_glitch_R11(input logic byp, input int exp_seen);
        int seen = 0;
        cfg_write({byp, 7'h00});
        wait_cyc(12);
        @(negedge clk); glitch_low = 1'b1;
        @(negedge clk);
        @(negedge clk); glitch_low = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (!mon_rdata[0]) seen = 1;
        end
        chk(seen == exp_seen, byp ? "R11 bypass shows glitch" : "R11 filter hides glitch",
            seen, exp_seen);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_cfg();
        t_monitor();
        run_burst("R6 count4", 4, 1, 0, 0, 4);
        run_burst("R6 clamp15", 15, 1, 0, 0, 9);
        run_burst("R7 early release", 9, 1, 3, 0, 3);
        run_burst("R7 sda high at request", 5, 0, 0, 0, 0);
        run_burst("R8 zero count", 0, 1, 0, 0, 0);
        run_burst("R5 stretch", 3, 1, 0, 20, 3);
        chk(min_gap >= HALF + 20, "R5 stretch widens gap", min_gap, HALF + 20);
        t_ignore_req_R9();
        t_done_clear_R4();
        t_master_ignored_R10();
        t_glitch_R11(1'b0, 0);
        t_glitch_R11(1'b1, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule